// File: doc/BRIEF.md
# Key-Locked Scratch RAM

This block is a small byte-wide RAM that sits in the CPU address space of a cartridge bank controller, on the page at $7F00-$7FFF. It has 128 bytes, addressed by CPU A6-A0. The controller does not look at CPU A7, so the same 128 bytes show up twice across the page. Software must first unlock the RAM by writing a key byte to a lock register before it can read or write the RAM. Until then, writes are dropped and reads leave the data bus floating. A system that shares the data bus with other sources uses the block's drive-enable output to decide whether the block owns the bus on a read.

The lock is a two-state machine. In `ST_LOCKED` the RAM is closed. A write of $A3 to the lock register takes the UNLOCK transition to `ST_OPEN`. In `ST_OPEN`, a lock-register write of any other value takes the RELOCK transition back to `ST_LOCKED`. A lock-register write of $A3 while already open stays in `ST_OPEN`. Every other cycle takes the HOLD transition and keeps the current state. Read results are registered: they appear on the ports in the cycle after the read strobe and last for one cycle.

Top module: `keyed_scratch_ram`

## Requirements
- R1: After reset the lock is in `ST_LOCKED`, so a read of $7F00 gives rd_oe=0 and rd_data=$00.
- R2: When unlocked, each of the 128 bytes, selected by CPU A6-A0 on page $7F, stores the byte written to it and returns it on a later read.
- R3: CPU A7 is ignored on the RAM page, so $7F80+i reaches the same byte as $7F00+i.
- R4: A write of $A3 to $7E78 or $7E79 unlocks the RAM. Because A7 is ignored, writes to $7EF8 and $7EF9 also reach the lock register.
- R5: A lock-register write of any value other than $A3 locks the RAM.
- R6: A RAM write while locked is discarded, and the byte keeps its earlier value.
- R7: A RAM read while locked gives rd_oe=0, rd_valid=0 and rd_data=$00.
- R8: A read of any address outside page $7F, including the lock register, gives rd_oe=0 and rd_data=$00.
- R9: A read that hits the unlocked RAM raises rd_oe with the data in the cycle after the strobe, and rd_oe falls again the cycle after that if no read follows.
- R10: A lock-register write is applied at the next clock edge. An access that starts in the following cycle sees the new lock state.
- R11: rd_valid always equals rd_oe, and rd_data is $00 whenever rd_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| rd_data | output | 8 | Read data, registered |
| rd_oe | output | 1 | Block drives the data bus this cycle |
| rd_valid | output | 1 | Read hit the unlocked RAM |

## Verification
A lock state that is wrong shows up within one read of the RAM page, in the cycle after the strobe. A state stuck open drives rd_oe where it must stay low, and a state stuck closed gives rd_oe=0 where data is expected. A wrong address decode, such as A7 not being ignored or a lock-register alias being missed, shows up as data from the wrong byte, or as a lock that never opens, on the first read after the mirrored or aliased access. A write that slips past the lock is only visible later, once the RAM is unlocked and the old byte is read back. The bench therefore always follows a locked write with an unlocked readback.

// File: rtl/kscr_pkg.sv
package kscr_pkg;

    typedef enum logic [0:0] {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_t;

    localparam int unsigned CPU_AW      = 16;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned RAM_BYTES   = 128;
    localparam logic [7:0]  UNLOCK_KEY  = 8'hA3;
    localparam logic [15:0] RAM_BASE    = 16'h7F00;
    localparam logic [15:0] LOCK_ADDR   = 16'h7E78;

endpackage

// File: rtl/kscr_decode.sv
module kscr_decode #(
    parameter int unsigned          AW        = 16,
    parameter int unsigned          DEPTH     = 128,
    parameter logic [AW-1:0]        RAM_BASE  = 16'h7F00,
    parameter logic [AW-1:0]        LOCK_ADDR = 16'h7E78,
    localparam int unsigned         IW        = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr,
    output logic          ram_hit,
    output logic          lock_hit,
    output logic [IW-1:0] index
);
    // The bit just above the index is ignored by the decode.
    localparam logic [AW-1:0] IGNORE_BIT = AW'(1) << IW;
    // The page is every bit above the index and the ignored bit.
    localparam logic [AW-1:0] PAGE_MASK  = ~((AW'(1) << (IW + 1)) - AW'(1));
    // The lock register answers at a pair of addresses.
    localparam logic [AW-1:0] LOCK_MASK  = ~(IGNORE_BIT | AW'(1));

    always_comb begin
        ram_hit  = ((addr & PAGE_MASK) == (RAM_BASE & PAGE_MASK));
        lock_hit = ((addr & LOCK_MASK) == (LOCK_ADDR & LOCK_MASK));
        index    = addr[IW-1:0];
    end

endmodule

// File: rtl/kscr_lock_fsm.sv
module kscr_lock_fsm
    import kscr_pkg::*;
#(
    parameter int unsigned       DW  = 8,
    parameter logic [DW-1:0]     KEY = 8'hA3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_wr,
    input  logic [DW-1:0] lock_data,
    output logic          ram_open
);
    lock_state_t state_q, state_d;

    // Next state: UNLOCK, RELOCK or HOLD.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (lock_wr && (lock_data == KEY)) state_d = ST_OPEN;
            ST_OPEN:   if (lock_wr && (lock_data != KEY)) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        ram_open = (state_q == ST_OPEN);
    end

endmodule

// File: rtl/kscr_store.sv
module kscr_store #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 128,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= re;
            rdata  <= re ? mem[idx] : '0;
        end
    end

endmodule

// File: rtl/keyed_scratch_ram.sv
module keyed_scratch_ram
    import kscr_pkg::*;
#(
    parameter int unsigned       AW        = CPU_AW,
    parameter int unsigned       DW        = BYTE_W,
    parameter int unsigned       DEPTH     = RAM_BYTES,
    parameter logic [AW-1:0]     RAM_PAGE  = RAM_BASE,
    parameter logic [AW-1:0]     LOCK_AT   = LOCK_ADDR,
    parameter logic [DW-1:0]     KEY       = UNLOCK_KEY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    output logic [DW-1:0] rd_data,
    output logic          rd_oe,
    output logic          rd_valid
);
    localparam int unsigned IW = $clog2(DEPTH);

    logic          ram_hit;
    logic          lock_hit;
    logic [IW-1:0] index;
    logic          ram_open;
    logic          hit_valid;

    kscr_decode #(
        .AW(AW), .DEPTH(DEPTH), .RAM_BASE(RAM_PAGE), .LOCK_ADDR(LOCK_AT)
    ) u_decode (
        .addr(cpu_addr), .ram_hit(ram_hit), .lock_hit(lock_hit), .index(index)
    );

    kscr_lock_fsm #(.DW(DW), .KEY(KEY)) u_lock (
        .clk(clk), .rst_n(rst_n),
        .lock_wr(cpu_wr && lock_hit), .lock_data(cpu_wdata),
        .ram_open(ram_open)
    );

    kscr_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(cpu_wr && ram_hit && ram_open),
        .re(cpu_rd && ram_hit && ram_open),
        .idx(index), .wdata(cpu_wdata),
        .rdata(rd_data), .rvalid(hit_valid)
    );

    assign rd_oe    = hit_valid;
    assign rd_valid = hit_valid;

endmodule

// File: rtl/keyed_scratch_ram_chk.sv
module keyed_scratch_ram_chk
    import kscr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_wr,
    input logic        cpu_rd,
    input logic [7:0]  rd_data,
    input logic        rd_oe,
    input logic        rd_valid,
    input logic        ram_open
);
    logic lock_wr_c, page_c;
    assign lock_wr_c = cpu_wr && ((cpu_addr & 16'hFF7E) == LOCK_ADDR);
    assign page_c    = ((cpu_addr & 16'hFF00) == RAM_BASE);

    p_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr_c && cpu_wdata == UNLOCK_KEY) |=> ram_open);

    p_relock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr_c && cpu_wdata != UNLOCK_KEY) |=> !ram_open);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_wr_c |=> $stable(ram_open));

    p_locked_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !ram_open) |=> !rd_oe);

    p_off_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !page_c) |=> !rd_oe);

    p_hit_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> ($past(cpu_rd) && $past(ram_open) && $past(page_c)));

    p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_oe |-> rd_data == 8'h00) and (rd_valid == rd_oe));

endmodule

bind keyed_scratch_ram keyed_scratch_ram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rd_data(rd_data), .rd_oe(rd_oe),
    .rd_valid(rd_valid), .ram_open(ram_open)
);

// File: tb/keyed_scratch_ram_test.sv
`timescale 1ns/1ps
module keyed_scratch_ram_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_oe;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    keyed_scratch_ram uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rd_data(rd_data), .rd_oe(rd_oe),
        .rd_valid(rd_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // Read result is sampled one cycle after the strobe, away from the edge.
    task automatic bus_read(input logic [15:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = rd_data; oe = rd_oe;
        check(rd_valid == rd_oe, "R11 valid", int'(rd_valid), int'(rd_oe));
        if (!rd_oe) check(rd_data == 8'h00, "R11 quiet", int'(rd_data), 0);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37) ^ 8'h5A);
    endfunction

    task automatic t_reset;
        logic [7:0] d; logic oe;
        bus_read(16'h7F00, d, oe);
        check(oe == 1'b0 && d == 8'h00, "R1 reset locked", int'(oe), 0);
    endtask

    task automatic t_keys;
        logic [7:0] d; logic oe;
        bus_write(16'h7E79, 8'hA3);
        bus_write(16'h7F10, 8'h3C);
        bus_read(16'h7F10, d, oe);
        check(oe && d == 8'h3C, "R4 unlock at 7E79", int'(d), 'h3C);
        bus_write(16'h7E78, 8'hA2);
        bus_read(16'h7F10, d, oe);
        check(!oe, "R5 relock", int'(oe), 0);
        check(d == 8'h00, "R7 locked read data", int'(d), 0);
        bus_write(16'h7EF8, 8'hA3);
        bus_read(16'h7F10, d, oe);
        check(oe && d == 8'h3C, "R4 unlock alias 7EF8", int'(d), 'h3C);
        bus_write(16'h7EF9, 8'h00);
        bus_read(16'h7F10, d, oe);
        check(!oe, "R5 relock alias 7EF9", int'(oe), 0);
    endtask

    task automatic t_locked_write;
        logic [7:0] d; logic oe;
        bus_write(16'h7E78, 8'hA3);
        bus_write(16'h7F05, 8'h11);
        bus_write(16'h7E78, 8'h5C);
        bus_write(16'h7F05, 8'h55);
        bus_write(16'h7F85, 8'h66);
        bus_write(16'h7E78, 8'hA3);
        bus_read(16'h7F05, d, oe);
        check(oe && d == 8'h11, "R6 locked write dropped", int'(d), 'h11);
    endtask

    task automatic t_fill;
        logic [7:0] d; logic oe;
        int bad = 0;
        bus_write(16'h7E78, 8'hA3);
        for (int i = 0; i < 128; i++) bus_write(16'h7F00 + 16'(i), pat(i));
        for (int i = 0; i < 128; i++) begin
            bus_read(16'h7F00 + 16'(i), d, oe);
            if (!(oe && d == pat(i))) begin
                bad++;
                $display("FAIL R2 byte %0d actual=%0h expected=%0h", i, d, pat(i));
            end
        end
        check(bad == 0, "R2 full array", bad, 0);
    endtask

    task automatic t_mirror;
        logic [7:0] d; logic oe;
        bus_write(16'h7F80 + 16'd42, 8'hE7);
        bus_read(16'h7F00 + 16'd42, d, oe);
        check(oe && d == 8'hE7, "R3 upper to lower", int'(d), 'hE7);
        bus_write(16'h7F00 + 16'd7, 8'h19);
        bus_read(16'h7F87, d, oe);
        check(oe && d == 8'h19, "R3 lower to upper", int'(d), 'h19);
        bus_read(16'h7FFF, d, oe);
        check(oe && d == pat(127), "R3 top alias", int'(d), int'(pat(127)));
    endtask

    task automatic t_off_page;
        logic [7:0] d; logic oe;
        bus_read(16'h7E78, d, oe);
        check(!oe && d == 8'h00, "R8 lock reg read", int'(oe), 0);
        bus_read(16'h7EFF, d, oe);
        check(!oe, "R8 7EFF", int'(oe), 0);
        bus_read(16'h6000, d, oe);
        check(!oe, "R8 6000", int'(oe), 0);
        bus_read(16'hFF00, d, oe);
        check(!oe, "R8 FF00", int'(oe), 0);
    endtask

    task automatic t_timing;
        // Back-to-back: unlock, write, read, then idle.
        bus_write(16'h7E78, 8'h00);
        @(negedge clk);
        cpu_addr = 16'h7E78; cpu_wdata = 8'hA3; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_addr = 16'h7F33; cpu_wdata = 8'h9D;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        check(rd_oe && rd_data == 8'h9D, "R10 key applies next cycle", int'(rd_data), 'h9D);
        check(rd_oe == 1'b1, "R9 data one cycle after strobe", int'(rd_oe), 1);
        @(negedge clk);
        check(rd_oe == 1'b0 && rd_data == 8'h00, "R9 one-cycle pulse", int'(rd_oe), 0);
        // Relock then read in the next cycle.
        cpu_addr = 16'h7E79; cpu_wdata = 8'h01; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = 16'h7F33; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        check(rd_oe == 1'b0, "R10 relock next cycle", int'(rd_oe), 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_keys();
        t_locked_write();
        t_fill();
        t_mirror();
        t_off_page();
        t_timing();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule